// File: doc/BRIEF.md
# Serial Flash Command Engine

This block is a memory-mapped SPI master that runs one short command on a serial flash device. Software loads an opcode and a packed pair of byte counts into a small byte-wide register file. It places any outgoing payload bytes into an eight-slot ring buffer through a single data port, returns the buffer pointer to the start, and sets the start bit. The engine lowers chip select and sends the opcode from its own register. It then sends the payload bytes taken from the ring, followed by filler bytes of 0xFF for the read phase. It then raises chip select again.

Transmit and receive share the ring. Every byte that crosses the wire after the opcode overwrites the slot it was taken from, so when the command finishes the ring holds the device's replies. The payload slots hold whatever the device returned while it was being written to, and the reply bytes follow them. Software rewinds the pointer, skips the payload slots and reads the reply through the same data port. Serial clock speed comes from a two-bit rate field.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, offset 0x0 (opcode) reads 0x00, offset 0x1 (counts) reads 0x00, offset 0x2 (control) reads 0x00, and offset 0xD (status) reads 0x10, which means rate 1 and pointer 0. Chip select is high and the serial clock is low.
- R2: Offset 0x1 holds the read count in bits 7:4 and the write count, which excludes the opcode, in bits 3:0. It reads back unchanged after a command completes.
- R3: Writing a 1 to bit 0 of offset 0x2 starts a command. That bit reads 1 while the command runs and returns to 0 by itself when it ends.
- R4: Writing a 1 to bit 4 of offset 0x2 returns the ring pointer to slot 0. The pointer reads back in bits 2:0 of offset 0xD.
- R5: Each read or write of offset 0xC accesses the slot at the pointer and then advances the pointer by one, modulo 8.
- R6: The wire order, most significant bit first, is: the opcode register, then the write-count bytes taken from the ring starting at the pointer, then one 0xFF byte for each byte of the read count.
- R7: Each byte received after the opcode is stored in the slot at the pointer, and the pointer then advances. Starting from slot 0, the pointer ends at (write count + read count) mod 8. A command with a write count of zero still captures every requested read byte.
- R8: A count field above 8 is treated as 8 on the wire, but the register keeps the value that was written.
- R9: Bits 5:4 of offset 0xD select the serial clock period: 4, 6 and 8 system clocks for rates 1, 2 and 3. The reserved value 0 behaves as rate 3.
- R10: Chip select stays low for the whole command. The serial clock idles low (mode 0). At least one serial clock period separates chip select falling from the first rising clock edge, and the last falling edge from chip select rising.
- R11: While a command runs, bus writes to the opcode, counts, control, data port and rate are ignored, and data port reads do not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe; advances the pointer at the data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The hardest case to reach from the ports is a command whose payload plus reply runs past eight bytes. In that case the capture wraps and overwrites slots that were already sent earlier in the same command. It is reached with a write count of 4 and a read count of 6, and with both counts set above the limit. A device model in the bench answers each byte position with a distinct value, so every slot can be traced to the wire position that filled it. Writes made while the engine is busy are driven straight after the start bit, and their lack of effect is then read back through the opcode register, the pointer and the captured slots.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
   localparam int BYTE_W = 8;

   localparam logic [3:0] OFS_OPCODE = 4'h0;
   localparam logic [3:0] OFS_COUNT  = 4'h1;
   localparam logic [3:0] OFS_CTRL   = 4'h2;
   localparam logic [3:0] OFS_DATA   = 4'hC;
   localparam logic [3:0] OFS_STAT   = 4'hD;

   localparam int CTRL_GO_BIT   = 0;
   localparam int CTRL_PCLR_BIT = 4;

   localparam logic [7:0] FILL_BYTE = 8'hFF;
   localparam logic [1:0] RATE_RESET = 2'd1;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_LOAD,
      ST_SHIFT,
      ST_HOLD
   } seq_state_t;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
   parameter int HALF_UNIT = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] rate,
   output logic       tick
);
   localparam int CNT_W = $clog2(4 * HALF_UNIT + 1);

   generate
      if (HALF_UNIT < 1) begin : g_bad_unit
         $error("spi_clk_div: HALF_UNIT must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] half;

   always_comb begin
      case (rate)
         2'd1:    half = CNT_W'(2 * HALF_UNIT);
         2'd2:    half = CNT_W'(3 * HALF_UNIT);
         default: half = CNT_W'(4 * HALF_UNIT);
      endcase
   end

   assign tick = run && (cnt_q == half - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (!run)     cnt_q <= '0;
      else if (tick)     cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
   end

   // R9: half period is never shorter than two system clocks
   p_tick_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         load,
   input  logic [W-1:0] tx,
   input  logic         miso,
   output logic         sclk,
   output logic         mosi,
   output logic         done,
   output logic [W-1:0] rx
);
   localparam int BIT_W = $clog2(W);

   generate
      if (W < 2) begin : g_bad_width
         $error("spi_byte_shift: W must be at least 2");
      end
   endgenerate

   logic             active_q;
   logic [W-1:0]     sh_q;
   logic [BIT_W-1:0] bit_q;

   assign mosi = active_q ? sh_q[W-1] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         sclk     <= 1'b0;
         sh_q     <= '0;
         rx       <= '0;
         bit_q    <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            active_q <= 1'b1;
            sh_q     <= tx;
            bit_q    <= '0;
            sclk     <= 1'b0;
         end else if (active_q && tick) begin
            if (!sclk) begin
               sclk <= 1'b1;
               rx   <= {rx[W-2:0], miso};
            end else begin
               sclk <= 1'b0;
               if (bit_q == BIT_W'(W - 1)) begin
                  active_q <= 1'b0;
                  done     <= 1'b1;
               end else begin
                  sh_q  <= sh_q << 1;
                  bit_q <= bit_q + 1'b1;
               end
            end
         end
      end
   end

   // R10: a byte always finishes with the clock back at its idle level
   p_done_sclk_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !sclk);
   // R6: a new byte is only loaded when the previous one has finished
   p_load_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !active_q);
endmodule

// File: rtl/spi_ring.sv
module spi_ring #(
   parameter int DEPTH = 8,
   parameter int W     = 8,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step_wr,
   input  logic             step_rd,
   input  logic [W-1:0]     wdata,
   input  logic             cap,
   input  logic [W-1:0]     cap_data,
   output logic [PTR_W-1:0] ptr,
   output logic [W-1:0]     cur
);
   generate
      if ((1 << PTR_W) != DEPTH || DEPTH < 2) begin : g_bad_depth
         $error("spi_ring: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0] slots [DEPTH];
   logic         wen;
   logic [W-1:0] wval;

   assign wen  = cap || step_wr;
   assign wval = cap ? cap_data : wdata;
   assign cur  = slots[ptr];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               slots[g] <= '0;
         else if (!clr && wen && ptr == PTR_W'(g)) slots[g] <= wval;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ptr <= '0;
      else if (clr)                        ptr <= '0;
      else if (cap || step_wr || step_rd)  ptr <= ptr + 1'b1;
   end

   p_ptr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> ptr == '0);
   p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && (step_wr || step_rd || cap)) |=> ptr == PTR_W'($past(ptr) + 1'b1));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
   import spi_cmd_pkg::*;
#(
   parameter int DEPTH     = 8,
   parameter int HALF_UNIT = 1,
   parameter int MAX_CNT   = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] bus_addr,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       spi_sclk,
   output logic       spi_cs_n,
   output logic       spi_mosi,
   input  logic       spi_miso
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int IDX_W = $clog2(2 * MAX_CNT + 2);

   generate
      if (MAX_CNT < 1 || MAX_CNT > 15) begin : g_bad_max
         $error("spi_cmd_engine: MAX_CNT must fit a 4-bit count field");
      end
      if (PTR_W > 3) begin : g_bad_ptr
         $error("spi_cmd_engine: pointer must fit the 3-bit status field");
      end
   endgenerate

   seq_state_t         st_q;
   logic               busy, wr_ok;
   logic [7:0]         opcode_q, count_q;
   logic [1:0]         rate_q;
   logic               cs_q, ph_q;
   logic [IDX_W-1:0]   idx_q, total;
   logic [3:0]         wr_eff, rd_eff;
   logic               go, pclr, sw_wr, sw_rd;
   logic               tick, sh_load, sh_done, cap;
   logic [7:0]         tx_byte, rx_byte, cur_slot;
   logic [PTR_W-1:0]   ptr;

   function automatic logic [3:0] clamp(input logic [3:0] c);
      return (c > 4'(MAX_CNT)) ? 4'(MAX_CNT) : c;
   endfunction

   assign busy   = (st_q != ST_IDLE);
   assign wr_ok  = bus_wr && !busy;
   assign go     = wr_ok && bus_addr == OFS_CTRL && bus_wdata[CTRL_GO_BIT];
   assign pclr   = wr_ok && bus_addr == OFS_CTRL && bus_wdata[CTRL_PCLR_BIT];
   assign sw_wr  = wr_ok && bus_addr == OFS_DATA;
   assign sw_rd  = bus_rd && !busy && bus_addr == OFS_DATA;

   assign wr_eff = clamp(count_q[3:0]);
   assign rd_eff = clamp(count_q[7:4]);
   assign total  = IDX_W'(1) + IDX_W'(wr_eff) + IDX_W'(rd_eff);

   // register file
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opcode_q <= '0;
         count_q  <= '0;
         rate_q   <= RATE_RESET;
      end else if (wr_ok) begin
         if (bus_addr == OFS_OPCODE) opcode_q <= bus_wdata;
         if (bus_addr == OFS_COUNT)  count_q  <= bus_wdata;
         if (bus_addr == OFS_STAT)   rate_q   <= bus_wdata[5:4];
      end
   end

   always_comb begin
      case (bus_addr)
         OFS_OPCODE: bus_rdata = opcode_q;
         OFS_COUNT:  bus_rdata = count_q;
         OFS_CTRL:   bus_rdata = {7'b0, busy};
         OFS_DATA:   bus_rdata = cur_slot;
         OFS_STAT:   bus_rdata = {2'b0, rate_q, 1'b0, 3'(ptr)};
         default:    bus_rdata = 8'h00;
      endcase
   end

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cs_q  <= 1'b1;
         ph_q  <= 1'b0;
         idx_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (go) begin
               st_q  <= ST_SETUP;
               cs_q  <= 1'b0;
               ph_q  <= 1'b0;
               idx_q <= '0;
            end
            ST_SETUP: if (tick) begin
               ph_q <= ~ph_q;
               if (ph_q) st_q <= ST_LOAD;
            end
            ST_LOAD: st_q <= ST_SHIFT;
            ST_SHIFT: if (sh_done) begin
               idx_q <= idx_q + 1'b1;
               if (IDX_W'(idx_q + 1'b1) < total) st_q <= ST_LOAD;
               else begin
                  st_q <= ST_HOLD;
                  ph_q <= 1'b0;
               end
            end
            ST_HOLD: if (tick) begin
               ph_q <= ~ph_q;
               if (ph_q) begin
                  st_q <= ST_IDLE;
                  cs_q <= 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign sh_load = (st_q == ST_LOAD);
   assign cap     = (st_q == ST_SHIFT) && sh_done && (idx_q != '0);
   assign tx_byte = (idx_q == '0)             ? opcode_q :
                    (idx_q <= IDX_W'(wr_eff)) ? cur_slot : FILL_BYTE;
   assign spi_cs_n = cs_q;

   spi_clk_div #(.HALF_UNIT(HALF_UNIT)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy), .rate(rate_q), .tick(tick)
   );

   spi_byte_shift #(.W(BYTE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(sh_load), .tx(tx_byte),
      .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .done(sh_done),
      .rx(rx_byte)
   );

   spi_ring #(.DEPTH(DEPTH), .W(BYTE_W)) u_ring (
      .clk(clk), .rst_n(rst_n), .clr(pclr), .step_wr(sw_wr), .step_rd(sw_rd),
      .wdata(bus_wdata), .cap(cap), .cap_data(rx_byte), .ptr(ptr),
      .cur(cur_slot)
   );

   p_cs_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> spi_cs_n);
   p_sclk_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);
   p_count_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(count_q));
   p_opcode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(opcode_q));
   p_go_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HOLD && tick && ph_q) |=> (!busy && spi_cs_n));
endmodule

// File: tb/spi_cmd_engine_test.sv
module spi_cmd_engine_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       spi_sclk, spi_cs_n, spi_mosi;
   logic       spi_miso = 1'b0;

   int n_chk = 0, n_err = 0;
   logic [7:0] tx_arr [16];
   logic [7:0] mosi_log [32];
   int sbit = 0, sbyte = 0, nbytes = 0;
   logic [7:0] sshift = '0;
   int cyc = 0, last_rise = 0, period = 0;
   int t_csfall = 0, t_lastfall = 0, setup_c = 0, hold_c = 0;
   bit first_rise = 1'b0;

   always #4 clk = ~clk;

   spi_cmd_engine uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso)
   );

   function automatic logic [7:0] resp(input int n);
      return 8'h3C ^ 8'(n * 37);
   endfunction

   // device model: mode 0, MSB first, distinct reply per byte position
   always @(negedge spi_cs_n) begin
      logic [7:0] r;
      sbit = 0; sbyte = 0; nbytes = 0;
      r = resp(0); spi_miso = r[7];
      t_csfall = cyc; first_rise = 1'b1;
   end
   always @(posedge spi_sclk) begin
      if (spi_cs_n === 1'b0) begin
         sshift = {sshift[6:0], spi_mosi};
         sbit++;
         if (sbit == 8) begin
            mosi_log[sbyte] = sshift;
            sbyte++; sbit = 0; nbytes = sbyte;
         end
      end
      period = cyc - last_rise; last_rise = cyc;
      if (first_rise) begin setup_c = cyc - t_csfall; first_rise = 1'b0; end
   end
   always @(negedge spi_sclk) begin
      logic [7:0] r;
      if (spi_cs_n === 1'b0) begin r = resp(sbyte); spi_miso = r[7 - sbit]; end
      t_lastfall = cyc;
   end
   always @(posedge spi_cs_n) hold_c = cyc - t_lastfall;
   always @(posedge clk) cyc = cyc + 1;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic wait_idle();
      logic [7:0] d;
      for (int i = 0; i < 5000; i++) begin
         bus_read(4'h2, d);
         if (!d[0]) break;
      end
   endtask

   task automatic run_txn(input logic [7:0] op, input logic [7:0] cnt, input int nload);
      logic [7:0] d;
      bus_write(4'h2, 8'h10);
      for (int i = 0; i < nload; i++) bus_write(4'hC, tx_arr[i]);
      bus_write(4'h2, 8'h10);
      bus_write(4'h1, cnt);
      bus_write(4'h0, op);
      bus_write(4'h2, 8'h01);
      bus_read(4'h2, d);
      chk("R3", "busy bit while running", d[0], 1);
      wait_idle();
   endtask

   task automatic read_slot(input int slot, input int exp, input string req);
      logic [7:0] d;
      bus_write(4'h2, 8'h10);
      for (int i = 0; i < slot; i++) bus_read(4'hC, d);
      bus_read(4'hC, d);
      chk(req, $sformatf("slot %0d", slot), d, exp);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      bus_read(4'h0, d); chk("R1", "opcode reset", d, 8'h00);
      bus_read(4'h1, d); chk("R1", "count reset", d, 8'h00);
      bus_read(4'h2, d); chk("R1", "ctrl reset", d, 8'h00);
      bus_read(4'hD, d); chk("R1", "status reset", d, 8'h10);
      chk("R1", "cs idle", spi_cs_n, 1);
      chk("R1", "sclk idle", spi_sclk, 0);
   endtask

   task automatic t_pointer();
      logic [7:0] d;
      bus_write(4'h2, 8'h10);
      for (int i = 0; i < 3; i++) bus_write(4'hC, 8'(i));
      bus_read(4'hD, d); chk("R5", "ptr after 3 writes", d[2:0], 3);
      bus_read(4'hC, d);
      bus_read(4'hD, d); chk("R5", "ptr after read", d[2:0], 4);
      for (int i = 0; i < 5; i++) bus_write(4'hC, 8'h40);
      bus_read(4'hD, d); chk("R5", "ptr wraps mod 8", d[2:0], 1);
      bus_write(4'h2, 8'h10);
      bus_read(4'hD, d); chk("R4", "ptr reset", d[2:0], 0);
   endtask

   task automatic t_basic();
      logic [7:0] d;
      tx_arr[0] = 8'hAA; tx_arr[1] = 8'h55; tx_arr[2] = 8'hC3;
      run_txn(8'h0B, 8'h23, 3);
      bus_read(4'h2, d); chk("R3", "busy self-clears", d[0], 0);
      chk("R6", "byte count on wire", nbytes, 6);
      chk("R6", "opcode first", mosi_log[0], 8'h0B);
      chk("R6", "payload 0", mosi_log[1], 8'hAA);
      chk("R6", "payload 2", mosi_log[3], 8'hC3);
      chk("R6", "filler", mosi_log[4], 8'hFF);
      bus_read(4'hD, d); chk("R7", "end ptr 3+2", d[2:0], 5);
      bus_read(4'h1, d); chk("R2", "count readback", d, 8'h23);
      read_slot(0, resp(1), "R7");
      read_slot(4, resp(5), "R7");
   endtask

   task automatic t_readonly();
      logic [7:0] d;
      run_txn(8'h9F, 8'h40, 0);
      chk("R7", "zero-write byte count", nbytes, 5);
      chk("R6", "filler with no payload", mosi_log[1], 8'hFF);
      bus_read(4'hD, d); chk("R7", "end ptr 0+4", d[2:0], 4);
      read_slot(3, resp(4), "R7");
   endtask

   task automatic t_wrap();
      logic [7:0] d;
      tx_arr[0] = 8'h11; tx_arr[1] = 8'h22; tx_arr[2] = 8'h33; tx_arr[3] = 8'h44;
      run_txn(8'h02, 8'h64, 4);
      chk("R6", "wrap payload 3", mosi_log[4], 8'h44);
      bus_read(4'hD, d); chk("R7", "end ptr wraps", d[2:0], 2);
      read_slot(0, resp(9), "R7");
      read_slot(1, resp(10), "R7");
      read_slot(2, resp(3), "R7");
   endtask

   task automatic t_clamp();
      logic [7:0] d;
      for (int i = 0; i < 8; i++) tx_arr[i] = 8'(8'hB0 + i);
      run_txn(8'h03, 8'h9F, 8);
      chk("R8", "clamped byte count", nbytes, 17);
      chk("R8", "last payload", mosi_log[8], 8'hB7);
      chk("R8", "first filler", mosi_log[9], 8'hFF);
      bus_read(4'h1, d); chk("R8", "count kept", d, 8'h9F);
      bus_read(4'hD, d); chk("R8", "end ptr", d[2:0], 0);
   endtask

   task automatic t_busy_ignore();
      logic [7:0] d;
      bus_write(4'h2, 8'h10);
      bus_write(4'h1, 8'h20);
      bus_write(4'h0, 8'h05);
      bus_write(4'h2, 8'h01);
      bus_write(4'h0, 8'h77);
      bus_write(4'h1, 8'h11);
      bus_write(4'hC, 8'hEE);
      bus_write(4'hD, 8'h30);
      bus_write(4'h2, 8'h10);
      bus_read(4'hC, d);
      wait_idle();
      bus_read(4'h0, d); chk("R11", "opcode kept", d, 8'h05);
      bus_read(4'h1, d); chk("R11", "count kept", d, 8'h20);
      bus_read(4'hD, d); chk("R11", "ptr and rate kept", d, 8'h12);
      read_slot(0, resp(1), "R11");
   endtask

   task automatic t_rate(input int rate, input int exp_period);
      logic [7:0] d;
      bus_write(4'hD, 8'(rate << 4));
      bus_read(4'hD, d); chk("R9", "rate readback", d[5:4], rate);
      run_txn(8'h05, 8'h10, 0);
      chk("R9", $sformatf("sclk period rate %0d", rate), period, exp_period);
      chk("R10", "cs setup", (setup_c >= exp_period) ? 1 : 0, 1);
      chk("R10", "cs hold", (hold_c >= exp_period) ? 1 : 0, 1);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_reset();
      t_pointer();
      t_basic();
      t_readonly();
      t_wrap();
      t_clamp();
      t_busy_ignore();
      t_rate(1, 4);
      t_rate(2, 6);
      t_rate(3, 8);
      t_rate(0, 8);
      finish_run();
   end
endmodule